// File: doc/BRIEF.md
# Memory Type Resolver

This block answers one question per cycle: which caching memory type applies to a given physical address. Software loads a small set of configuration registers through a write port. A query supplies an address, and one cycle later the block returns an 8-bit type code with a valid strobe.

The block resolves a query in this order:

- When the global enable is clear, the answer is an invalid marker.
- When the fixed-range table applies, the address is a low address and it indexes a table of type bytes. The table is split into windows of 64 KB, 16 KB and 4 KB granularity.
- Otherwise the block compares the address against a bank of base/mask range registers at page (4 KB) granularity.
  - Overlapping hits are merged by a precedence rule.
  - When nothing hits, the default type is returned.

Type codes are: uncacheable 0x00, write-combining 0x01, write-through 0x04, write-protect 0x05, write-back 0x06, invalid 0xFF.

Register map, by word address on `wr_addr`:

- 0x00 is the control word:
  - bits 7:0 hold the default type;
  - bit 10 is the fixed enable;
  - bit 11 is the global enable.
- 0x01 to 0x0B are the eleven fixed-table words. Word `w` carries table entries `8*(w-1)` to `8*(w-1)+7`, and entry `8*(w-1)+j` sits in byte `j`.
- From 0x10 the range registers follow in pairs, base then mask: range `n` has its base at `0x10+2n` and its mask at `0x11+2n`.
  - In a base word, bits 35:12 hold the base and bits 7:0 the type.
  - In a mask word, bits 35:12 hold the mask and bit 11 is the range valid bit.

Top module: `mtype_resolver`

## Requirements
- R1: A query accepted while `q_req` is high is answered by `rsp_valid` high on the next cycle. `rsp_valid` is low in any cycle that follows a cycle without `q_req`, and `rsp_type` holds its value over that cycle.
- R2: When bit 11 of the control word is clear, every query returns 0xFF.
- R3: The control word holds the default type in bits 7:0, the fixed enable in bit 10 and the global enable in bit 11. The default type is returned when the block is enabled, the fixed table does not apply, and no valid range matches.
- R4: The fixed table is used only when all three of these hold: the address is below 0x100000, the instance is built with fixed support, and bit 10 of the control word is set. When it is used, it takes precedence over the range registers. Otherwise low addresses resolve through the ranges and the default type.
- R5: The fixed table has 88 entries, indexed as follows:
  - below 0x80000, the index is address bits 18:16;
  - from 0x80000 to 0xBFFFF, the index is 8 plus (address-0x80000)>>14;
  - from 0xC0000 to 0xFFFFF, the index is 24 plus (address-0xC0000)>>12.
  The entry byte is returned as the type.
- R6: A range takes part only when bit 11 of its mask word is set. It matches when (address AND mask) equals (base AND mask), with address bits 11:0 excluded from the comparison. Its type is bits 7:0 of its base word.
- R7: If any matching valid range has type 0x00, the result is 0x00.
- R8: Matching ranges that all carry the same type give that type. A mix of write-back (0x06) and write-through (0x04) gives 0x04.
- R9: Any other mix of differing types among matching ranges gives 0x00.
- R10: A register write in the same cycle as a query does not affect that query's answer. It does affect the next query.
- R11: After reset, `rsp_valid` is low, `rsp_type` is 0xFF, and all configuration is zero, so queries return 0xFF.
- R12: Writes to word addresses outside the map are ignored. This includes range pairs at or beyond the instance's range count and fixed words in an instance without fixed support.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register word address |
| wr_data | input | 64 | Register write data |
| q_req | input | 1 | Query strobe |
| q_addr | input | 36 | Physical address to resolve |
| rsp_valid | output | 1 | Answer valid, one cycle after the query |
| rsp_type | output | 8 | Resolved memory type code |

## Verification
The bench builds two instances on shared inputs.

The first instance uses the default values: eight ranges, 36-bit addresses and fixed support. This brings within reach:

- all three fixed windows and their edges;
- ranges above the 32-bit boundary;
- the three-way overlap rules among eight ranges.

The second instance has fixed support removed and only two ranges. It resolves low addresses through ranges and the default type. It shows that writes aimed at ranges the instance lacks leave its answers untouched.

// File: rtl/mtype_pkg.sv
package mtype_pkg;

    localparam logic [7:0] MT_UC  = 8'h00;
    localparam logic [7:0] MT_WC  = 8'h01;
    localparam logic [7:0] MT_WT  = 8'h04;
    localparam logic [7:0] MT_WP  = 8'h05;
    localparam logic [7:0] MT_WB  = 8'h06;
    localparam logic [7:0] MT_INV = 8'hFF;

    localparam int FIX64_N   = 8;
    localparam int FIX16_N   = 16;
    localparam int FIX4_N    = 64;
    localparam int FIX_N     = FIX64_N + FIX16_N + FIX4_N;
    localparam int FIX_WORDS = FIX_N / 8;

    localparam int CTL_FIX_EN_BIT = 10;
    localparam int CTL_GLB_EN_BIT = 11;
    localparam int RNG_VALID_BIT  = 11;
    localparam int PAGE_BITS      = 12;

    typedef enum logic [1:0] {
        SRC_OFF,
        SRC_FIXED,
        SRC_RANGE,
        SRC_DEFAULT
    } mt_src_e;

    // Merge an accumulated type with one more matching range type.
    function automatic logic [7:0] mt_merge(input logic [7:0] acc, input logic [7:0] nxt);
        logic [7:0] r;
        if (acc == MT_INV)
            r = nxt;
        else if (acc == nxt)
            r = acc;
        else if (acc == MT_UC || nxt == MT_UC)
            r = MT_UC;
        else if ((acc == MT_WB && nxt == MT_WT) || (acc == MT_WT && nxt == MT_WB))
            r = MT_WT;
        else
            r = MT_UC;
        return r;
    endfunction

endpackage

// File: rtl/mtype_cfg_regs.sv
module mtype_cfg_regs
    import mtype_pkg::*;
#(
    parameter int NUM_VAR   = 8,
    parameter int PA_W      = 36,
    parameter int WDATA_W   = 64,
    parameter int WADDR_W   = 8,
    parameter int HAS_FIXED = 1,
    parameter int VAR_ADDR0 = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [WADDR_W-1:0]                wr_addr,
    input  logic [WDATA_W-1:0]                wr_data,
    output logic [7:0]                        def_type,
    output logic                              fix_en,
    output logic                              glb_en,
    output logic [FIX_N-1:0][7:0]             fix_tbl,
    output logic [NUM_VAR-1:0][PA_W-1:0]      rng_base,
    output logic [NUM_VAR-1:0][PA_W-1:0]      rng_mask
);

    localparam logic [WADDR_W-1:0] CTL_ADDR = '0;

    // Control word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            def_type <= '0;
            fix_en   <= 1'b0;
            glb_en   <= 1'b0;
        end else if (wr_en && wr_addr == CTL_ADDR) begin
            def_type <= wr_data[7:0];
            fix_en   <= wr_data[CTL_FIX_EN_BIT];
            glb_en   <= wr_data[CTL_GLB_EN_BIT];
        end
    end

    // Fixed table, present only when the variant asks for it
    generate
        if (HAS_FIXED != 0) begin : g_fix
            for (genvar w = 0; w < FIX_WORDS; w++) begin : g_word
                localparam logic [WADDR_W-1:0] W_ADDR = WADDR_W'(w + 1);
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        for (int j = 0; j < 8; j++)
                            fix_tbl[w*8 + j] <= '0;
                    end else if (wr_en && wr_addr == W_ADDR) begin
                        for (int j = 0; j < 8; j++)
                            fix_tbl[w*8 + j] <= wr_data[8*j +: 8];
                    end
                end
            end
        end else begin : g_nofix
            assign fix_tbl = '0;
        end
    endgenerate

    // Range register pairs
    generate
        for (genvar n = 0; n < NUM_VAR; n++) begin : g_rng
            localparam logic [WADDR_W-1:0] B_ADDR = WADDR_W'(VAR_ADDR0 + 2*n);
            localparam logic [WADDR_W-1:0] M_ADDR = WADDR_W'(VAR_ADDR0 + 2*n + 1);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rng_base[n] <= '0;
                    rng_mask[n] <= '0;
                end else if (wr_en) begin
                    if (wr_addr == B_ADDR) rng_base[n] <= wr_data[PA_W-1:0];
                    if (wr_addr == M_ADDR) rng_mask[n] <= wr_data[PA_W-1:0];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/mtype_fixed_sel.sv
module mtype_fixed_sel
    import mtype_pkg::*;
#(
    parameter int PA_W      = 36,
    parameter int HAS_FIXED = 1
) (
    input  logic [PA_W-1:0]      addr,
    input  logic                 fix_en,
    input  logic [FIX_N-1:0][7:0] fix_tbl,
    output logic                 fix_hit,
    output logic [7:0]           fix_type
);

    localparam int IDX_W = $clog2(FIX_N);

    logic [IDX_W-1:0] idx;
    logic             low_mem;
    logic             unused_addr;

    assign unused_addr = ^addr[11:0];
    assign low_mem     = (addr[PA_W-1:20] == '0);

    // Window select: 64 KB below 0x80000, 16 KB up to 0xBFFFF, 4 KB above
    always_comb begin
        if (!addr[19])
            idx = IDX_W'(addr[18:16]);
        else if (!addr[18])
            idx = IDX_W'(FIX64_N) + IDX_W'(addr[17:14]);
        else
            idx = IDX_W'(FIX64_N + FIX16_N) + IDX_W'(addr[17:12]);
    end

    generate
        if (HAS_FIXED != 0) begin : g_fix
            assign fix_hit  = low_mem && fix_en;
            assign fix_type = fix_tbl[idx];
        end else begin : g_nofix
            logic unused_fix;
            assign unused_fix = ^{fix_tbl, fix_en, idx, low_mem};
            assign fix_hit  = 1'b0;
            assign fix_type = MT_INV;
        end
    endgenerate

endmodule

// File: rtl/mtype_range_resolve.sv
module mtype_range_resolve
    import mtype_pkg::*;
#(
    parameter int NUM_VAR = 8,
    parameter int PA_W    = 36
) (
    input  logic [PA_W-1:0]              addr,
    input  logic [NUM_VAR-1:0][PA_W-1:0] rng_base,
    input  logic [NUM_VAR-1:0][PA_W-1:0] rng_mask,
    output logic                         rng_any,
    output logic [7:0]                   rng_type
);

    localparam int PG_W = PA_W - PAGE_BITS;

    logic [NUM_VAR-1:0] hit;
    logic [7:0]         acc;

    generate
        for (genvar n = 0; n < NUM_VAR; n++) begin : g_cmp
            logic [PG_W-1:0] pm;
            logic            unused_low;
            assign pm         = rng_mask[n][PA_W-1:PAGE_BITS];
            assign unused_low = ^{rng_mask[n][RNG_VALID_BIT-1:0], rng_base[n][PAGE_BITS-1:8]};
            assign hit[n] = rng_mask[n][RNG_VALID_BIT] &&
                            ((addr[PA_W-1:PAGE_BITS] & pm) == (rng_base[n][PA_W-1:PAGE_BITS] & pm));
        end
    endgenerate

    logic unused_addr;
    assign unused_addr = ^addr[PAGE_BITS-1:0];

    always_comb begin
        acc = MT_INV;
        for (int n = 0; n < NUM_VAR; n++)
            if (hit[n]) acc = mt_merge(acc, rng_base[n][7:0]);
    end

    assign rng_any  = |hit;
    assign rng_type = acc;

endmodule

// File: rtl/mtype_resolver.sv
module mtype_resolver
    import mtype_pkg::*;
#(
    parameter int NUM_VAR   = 8,
    parameter int PA_W      = 36,
    parameter int WDATA_W   = 64,
    parameter int WADDR_W   = 8,
    parameter int HAS_FIXED = 1,
    parameter int VAR_ADDR0 = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WADDR_W-1:0] wr_addr,
    input  logic [WDATA_W-1:0] wr_data,
    input  logic               q_req,
    input  logic [PA_W-1:0]    q_addr,
    output logic               rsp_valid,
    output logic [7:0]         rsp_type
);

    logic [7:0]                   cfg_def_type;
    logic                         cfg_fix_en;
    logic                         cfg_glb_en;
    logic [FIX_N-1:0][7:0]        fix_tbl;
    logic [NUM_VAR-1:0][PA_W-1:0] rng_base;
    logic [NUM_VAR-1:0][PA_W-1:0] rng_mask;

    logic       fix_hit;
    logic [7:0] fix_type;
    logic       rng_any;
    logic [7:0] rng_type;
    mt_src_e    src;
    logic [7:0] res_type;

    mtype_cfg_regs #(
        .NUM_VAR(NUM_VAR), .PA_W(PA_W), .WDATA_W(WDATA_W), .WADDR_W(WADDR_W),
        .HAS_FIXED(HAS_FIXED), .VAR_ADDR0(VAR_ADDR0)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .def_type(cfg_def_type), .fix_en(cfg_fix_en), .glb_en(cfg_glb_en),
        .fix_tbl(fix_tbl), .rng_base(rng_base), .rng_mask(rng_mask)
    );

    mtype_fixed_sel #(.PA_W(PA_W), .HAS_FIXED(HAS_FIXED)) u_fix (
        .addr(q_addr), .fix_en(cfg_fix_en), .fix_tbl(fix_tbl),
        .fix_hit(fix_hit), .fix_type(fix_type)
    );

    mtype_range_resolve #(.NUM_VAR(NUM_VAR), .PA_W(PA_W)) u_rng (
        .addr(q_addr), .rng_base(rng_base), .rng_mask(rng_mask),
        .rng_any(rng_any), .rng_type(rng_type)
    );

    // Source priority: disabled, fixed table, ranges, default
    always_comb begin
        if (!cfg_glb_en)   src = SRC_OFF;
        else if (fix_hit)  src = SRC_FIXED;
        else if (rng_any)  src = SRC_RANGE;
        else               src = SRC_DEFAULT;
    end

    always_comb begin
        unique case (src)
            SRC_OFF:     res_type = MT_INV;
            SRC_FIXED:   res_type = fix_type;
            SRC_RANGE:   res_type = rng_type;
            SRC_DEFAULT: res_type = cfg_def_type;
            default:     res_type = MT_INV;
        endcase
    end

    // Registered answer; configuration seen is the pre-edge value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_type  <= MT_INV;
        end else begin
            rsp_valid <= q_req;
            if (q_req) rsp_type <= res_type;
        end
    end

endmodule

// File: rtl/mtype_resolver_chk.sv
module mtype_resolver_chk
    import mtype_pkg::*;
#(
    parameter int NUM_VAR   = 8,
    parameter int PA_W      = 36,
    parameter int HAS_FIXED = 1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         q_req,
    input logic [PA_W-1:0]              q_addr,
    input logic                         rsp_valid,
    input logic [7:0]                   rsp_type,
    input logic                         cfg_glb_en,
    input logic                         cfg_fix_en,
    input logic [7:0]                   cfg_def_type,
    input logic [NUM_VAR-1:0][PA_W-1:0] rng_base,
    input logic [NUM_VAR-1:0][PA_W-1:0] rng_mask
);

    logic fixwin;
    logic uc_hit;
    logic any_hit;

    assign fixwin = (HAS_FIXED != 0) && cfg_fix_en && (q_addr < PA_W'(36'h10_0000));

    always_comb begin
        uc_hit  = 1'b0;
        any_hit = 1'b0;
        for (int n = 0; n < NUM_VAR; n++) begin
            if (rng_mask[n][RNG_VALID_BIT] &&
                (((q_addr ^ rng_base[n]) & rng_mask[n]) >> PAGE_BITS) == '0) begin
                any_hit = 1'b1;
                if (rng_base[n][7:0] == MT_UC) uc_hit = 1'b1;
            end
        end
    end

    // R1
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_req |=> rsp_valid);

    // R1
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q_req |=> !rsp_valid);

    // R1
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q_req |=> $stable(rsp_type));

    // R2
    glb_off_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_req && !cfg_glb_en) |=> rsp_type == MT_INV);

    // R7
    uc_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_req && cfg_glb_en && !fixwin && uc_hit) |=> rsp_type == MT_UC);

    // R3
    default_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_req && cfg_glb_en && !fixwin && !any_hit) |=> rsp_type == $past(cfg_def_type));

endmodule

bind mtype_resolver mtype_resolver_chk #(
    .NUM_VAR(NUM_VAR), .PA_W(PA_W), .HAS_FIXED(HAS_FIXED)
) u_chk (
    .clk(clk), .rst_n(rst_n), .q_req(q_req), .q_addr(q_addr),
    .rsp_valid(rsp_valid), .rsp_type(rsp_type),
    .cfg_glb_en(cfg_glb_en), .cfg_fix_en(cfg_fix_en), .cfg_def_type(cfg_def_type),
    .rng_base(rng_base), .rng_mask(rng_mask)
);

// File: tb/sim_mtype_resolver.sv
module sim_mtype_resolver;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic        q_req = 1'b0;
    logic [35:0] q_addr = '0;
    logic        rsp_valid, rsp_valid1;
    logic [7:0]  rsp_type, rsp_type1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mtype_resolver u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .q_req(q_req), .q_addr(q_addr), .rsp_valid(rsp_valid), .rsp_type(rsp_type)
    );

    mtype_resolver #(.NUM_VAR(2), .HAS_FIXED(0)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .q_req(q_req), .q_addr(q_addr), .rsp_valid(rsp_valid1), .rsp_type(rsp_type1)
    );

    // {requirement number, address, expected type} for u0
    localparam logic [47:0] VEC [18] = '{
        {4'd5,  36'h0_0003_5000, 8'h13},  // R5 64 KB window
        {4'd5,  36'h0_0007_FFFF, 8'h17},  // R5 last 64 KB entry
        {4'd5,  36'h0_0008_0000, 8'h18},  // R5 first 16 KB entry
        {4'd5,  36'h0_000B_FFFF, 8'h27},  // R5 last 16 KB entry
        {4'd5,  36'h0_000C_0000, 8'h28},  // R5 first 4 KB entry
        {4'd5,  36'h0_000F_FFFF, 8'h67},  // R5 last 4 KB entry
        {4'd5,  36'h0_000D_3456, 8'h3B},  // R5 mid 4 KB entry
        {4'd3,  36'h0_0010_0000, 8'h05},  // R3 just above fixed area
        {4'd8,  36'h0_4123_4000, 8'h04},  // R8 WB with WT
        {4'd7,  36'h0_5080_0000, 8'h00},  // R7 UC overlap
        {4'd9,  36'h0_6000_0ABC, 8'h00},  // R9 WB with WP
        {4'd6,  36'h0_6000_1000, 8'h06},  // R6 page outside small range
        {4'd6,  36'h8_1234_5678, 8'h01},  // R6 range above 32 bits
        {4'd6,  36'h0_7000_0000, 8'h06},  // R6 invalid range ignored
        {4'd8,  36'h0_7800_0040, 8'h06},  // R8 identical types
        {4'd3,  36'h1_0000_0000, 8'h05},  // R3 no match
        {4'd3,  36'h0_3FFF_FFFF, 8'h05},  // R3 below range
        {4'd3,  36'h0_8000_0000, 8'h05}   // R3 above range
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic query(input logic [35:0] a);
        @(negedge clk);
        q_req = 1'b1; q_addr = a;
        @(negedge clk);
        q_req = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] held;
        // R11 reset state
        repeat (3) @(negedge clk);
        check("R11 rsp_valid in reset", {7'b0, rsp_valid}, 8'h00);
        check("R11 rsp_type in reset", rsp_type, 8'hFF);
        rst_n = 1'b1;
        query(36'h0_0000_1000);
        check("R11 zeroed config answer", rsp_type, 8'hFF);
        check("R1 valid after query", {7'b0, rsp_valid}, 8'h01);

        // Program: default WP, fixed and global enabled
        wr(8'h00, 64'hC05);
        for (int w = 0; w < 11; w++) begin
            logic [63:0] d;
            for (int j = 0; j < 8; j++) d[8*j +: 8] = 8'(w*8 + j + 16);
            wr(8'(w + 1), d);
        end
        wr(8'h10, 64'h0_4000_0006); wr(8'h11, 64'hF_C000_0800);
        wr(8'h12, 64'h0_4000_0004); wr(8'h13, 64'hF_F000_0800);
        wr(8'h14, 64'h0_5000_0000); wr(8'h15, 64'hF_FF00_0800);
        wr(8'h16, 64'h0_6000_0F05); wr(8'h17, 64'hF_FFFF_FFFF);
        wr(8'h18, 64'h8_0000_0001); wr(8'h19, 64'hF_8000_0800);
        wr(8'h1A, 64'h0_7000_0000); wr(8'h1B, 64'hF_F000_0000);
        wr(8'h1C, 64'h0_0000_0000); wr(8'h1D, 64'hF_FFF0_0800);
        wr(8'h1E, 64'h0_7800_0006); wr(8'h1F, 64'hF_F800_0800);
        wr(8'h0C, 64'hFFFF_FFFF_FFFF_FFFF); // R12 unmapped word

        for (int i = 0; i < 18; i++) begin
            query(VEC[i][43:8]);
            check($sformatf("R%0d vector %0d", VEC[i][47:44], i), rsp_type, VEC[i][7:0]);
        end

        // R1 idle cycle: strobe drops, type held
        held = rsp_type;
        @(negedge clk);
        check("R1 valid low when idle", {7'b0, rsp_valid}, 8'h00);
        check("R1 type held when idle", rsp_type, held);

        // R4 instance without fixed support; R12 ranges it lacks
        query(36'h0_0003_5000);
        check("R4 no fixed support u1", rsp_type1, 8'h05);
        query(36'h0_7800_0040);
        check("R12 missing range ignored u1", rsp_type1, 8'h06);
        query(36'h0_4123_4000);
        check("R8 u1 WB with WT", rsp_type1, 8'h04);

        // R4 fixed enable clear: low address falls to ranges
        wr(8'h00, 64'h805);
        query(36'h0_0003_5000);
        check("R4 fixed disabled range UC", rsp_type, 8'h00);
        query(36'h0_000F_FFFF);
        check("R4 fixed disabled top entry", rsp_type, 8'h00);

        // R10 write in the same cycle as a query
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h00; wr_data = 64'h801;
        q_req = 1'b1; q_addr = 36'h1_0000_0000;
        @(negedge clk);
        wr_en = 1'b0; q_req = 1'b0;
        check("R10 same-cycle query uses old default", rsp_type, 8'h05);
        query(36'h1_0000_0000);
        check("R10 next query uses new default", rsp_type, 8'h01);

        // R2 global enable clear
        wr(8'h00, 64'h406);
        query(36'h0_0003_5000);
        check("R2 disabled low address", rsp_type, 8'hFF);
        query(36'h0_4123_4000);
        check("R2 disabled range address", rsp_type, 8'hFF);
        check("R2 disabled u1", rsp_type1, 8'hFF);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule